// File: doc/BRIEF.md
# TMR Shift-Register Upset Test Harness

This block is a self-checking test vehicle for measuring how sensitive flip-flop storage is to single-event upsets. One pattern source feeds a set of long shift-register lanes. The lower half of the lanes are plain flip-flop chains. The upper half are triplicated: every stage holds three copies, and a bitwise two-of-three vote feeds the next stage. A monitor at the end of each lane compares the lane output with the value the pattern source produced one lane depth earlier. It counts every wrong bit. When wrong bits arrive back to back for long enough, it latches a functional-failure flag.

Two further monitors watch for loss of the programmed configuration. The first watches an external configuration-done level. The second drives a canary signal straight through to an output and compares the copy that returns with the original. Upsets are injected only by the testbench, which overwrites chosen flip-flops. Comparison is held off while the lanes refill, after reset or after any pattern change, so those refills never count as errors.

Top module: `upset_harness`

## Requirements
- R1: There are LANES lanes (default 8) of DEPTH stages each (default 500). Lanes 0 to LANES/2-1 are plain chains and the remaining lanes are triplicated. Bit i of `chain_out` is the output of lane i, and that lane's error count sits at `err_cnt[i*CNT_W +: CNT_W]`.
- R2: `pat_sel` chooses the pattern: 2'b00 gives all zeros, 2'b01 gives all ones, 2'b10 gives a checkerboard that inverts every clock, and 2'b11 behaves as all zeros. With the checkerboard, every lane output inverts on each clock.
- R3: An upset in one copy of a triplicated stage never reaches that lane's output and adds nothing to its error count. This holds in any stage, and even when every stage of that copy is upset.
- R4: An upset injected into stage k of a plain lane appears on `chain_out` exactly once, DEPTH-1-k clocks after injection, and adds exactly one to that lane's error count.
- R5: Each lane counts every compared wrong output bit. The counter saturates at 2^CNT_W-1 and does not wrap.
- R6: A lane's failure flag sets when FAIL_RUN (default 16) wrong bits arrive on consecutive clocks. It stays set until cleared. A run of FAIL_RUN-1 does not set it, and any correct bit restarts the run.
- R7: Outputs are not compared during the first DEPTH clocks after reset, or after any change of `pat_sel`. Pattern changes therefore add no errors.
- R8: `cfg_lost` sets on the clock after `done_in` is seen low. It stays set until cleared.
- R9: `canary_out` equals `canary_in`. `cfg_degraded` sets on the clock after `canary_back` differs from `canary_in`, and it stays set until cleared.
- R10: `clr` synchronously zeroes all error counts, failure flags, `cfg_lost` and `cfg_degraded`. It wins over any detection in the same cycle.
- R11: While `rst_n` is low on a clock edge, all counts, flags and lane outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of counts and flags |
| pat_sel | input | 2 | Test pattern choice |
| done_in | input | 1 | External configuration-done level |
| canary_in | input | 1 | Canary signal entering the feed-through |
| canary_back | input | 1 | Canary as it returns from the feed-through |
| canary_out | output | 1 | Feed-through copy of the canary |
| chain_out | output | LANES | Output bit of each lane |
| err_cnt | output | LANES*CNT_W | Packed per-lane saturating error counts |
| fail_flags | output | LANES | Per-lane sticky functional-failure flags |
| cfg_lost | output | 1 | Sticky flag: configuration-done was seen low |
| cfg_degraded | output | 1 | Sticky flag: canary mismatch was seen |

## Verification
A lane's error detection and the synchronous clear can land on the same edge. So can a low configuration-done level and the clear. The bench pins one plain lane's register to all ones, so a wrong bit arrives on every clock, and pulses `clr` while that happens. It also drives `done_in` low in the same cycle as `clr`. The result is judged right when the count and flags read zero after the shared edge and then grow again by exactly one per clock, and when `cfg_lost` appears only one clock later.

// File: rtl/harness_pkg.sv
// Package harness_pkg
// Shared pattern encoding and the pattern-bit function used by the upset
// harness. Assumes a two-bit pattern select; the spare code reads as zeros.
package harness_pkg;

    typedef enum logic [1:0] {
        PAT_ZERO  = 2'b00,
        PAT_ONE   = 2'b01,
        PAT_CHECK = 2'b10,
        PAT_SPARE = 2'b11
    } pat_e;

    // Bit produced by a pattern for a given checkerboard phase.
    function automatic logic pat_bit(pat_e mode, logic phase);
        case (mode)
            PAT_ONE:   return 1'b1;
            PAT_CHECK: return phase;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pattern_gen.sv
// Module pattern_gen
// Produces the lane input bit and the expected lane output bit. Also
// produces the armed signal, which allows comparison once the lanes have
// refilled. The checkerboard phase runs freely. A copy of the phase goes
// through a delay line of DEPTH flops, so the expected bit lines up with
// the lane outputs. Assumes DEPTH >= 2 and that pat_sel changes only
// between clock edges.
module pattern_gen
    import harness_pkg::*;
#(
    parameter int DEPTH = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pat_sel,
    output logic       src_bit,
    output logic       exp_bit,
    output logic       armed
);
    localparam int             WW    = $clog2(DEPTH + 1);
    localparam logic [WW-1:0]  WFULL = WW'(DEPTH);

    pat_e              mode_q;
    logic              phase;
    logic [DEPTH-1:0]  phase_line;
    logic [WW-1:0]     warm_cnt;

    // Phase toggle, phase delay line, registered mode and warm-up count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= PAT_ZERO;
            phase      <= 1'b0;
            phase_line <= '0;
            warm_cnt   <= '0;
        end else begin
            phase      <= ~phase;
            phase_line <= {phase_line[DEPTH-2:0], phase};
            mode_q     <= pat_e'(pat_sel);
            if (pat_sel != mode_q)
                warm_cnt <= '0;
            else if (warm_cnt != WFULL)
                warm_cnt <= warm_cnt + 1'b1;
        end
    end

    // Lane input now, and the value expected at the lane outputs.
    always_comb begin
        src_bit = pat_bit(mode_q, phase);
        exp_bit = pat_bit(mode_q, phase_line[DEPTH-1]);
        armed   = (warm_cnt == WFULL);
    end

endmodule

// File: rtl/shift_chain.sv
// Module shift_chain
// One lane of DEPTH flip-flop stages. With TRIPLE = 0 it is a plain
// chain. With TRIPLE = 1 each stage holds three copies, and the next stage
// loads the bitwise two-of-three vote of the current stage. The output is
// the vote of the last stage. Assumes DEPTH >= 2.
module shift_chain #(
    parameter int DEPTH  = 500,
    parameter bit TRIPLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stg_a;

    if (TRIPLE) begin : g_tmr
        logic [DEPTH-1:0] stg_b;
        logic [DEPTH-1:0] stg_c;
        logic [DEPTH-1:0] vote;

        // Two-of-three vote of every stage.
        assign vote = (stg_a & stg_b) | (stg_a & stg_c) | (stg_b & stg_c);

        // All three copies shift the voted value forward.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_a <= '0;
                stg_b <= '0;
                stg_c <= '0;
            end else begin
                stg_a <= {vote[DEPTH-2:0], din};
                stg_b <= {vote[DEPTH-2:0], din};
                stg_c <= {vote[DEPTH-2:0], din};
            end
        end

        assign dout = vote[DEPTH-1];
    end else begin : g_plain
        // Plain shift of the single copy.
        always_ff @(posedge clk) begin
            if (!rst_n) stg_a <= '0;
            else        stg_a <= {stg_a[DEPTH-2:0], din};
        end

        assign dout = stg_a[DEPTH-1];
    end

endmodule

// File: rtl/chain_monitor.sv
// Module chain_monitor
// Checks one lane output against the expected bit while armed. It counts
// every wrong bit in a saturating counter. It sets a sticky failure flag
// once FAIL_RUN wrong bits arrive back to back. Clear wins over detection.
// Assumes FAIL_RUN >= 1.
module chain_monitor #(
    parameter int CNT_W    = 16,
    parameter int FAIL_RUN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             armed,
    input  logic             dout,
    input  logic             exp_bit,
    output logic [CNT_W-1:0] err_cnt,
    output logic             fail
);
    localparam int               RW       = $clog2(FAIL_RUN + 1);
    localparam logic [RW-1:0]    RUN_LAST = RW'(FAIL_RUN - 1);
    localparam logic [RW-1:0]    RUN_TOP  = RW'(FAIL_RUN);
    localparam logic [CNT_W-1:0] CNT_TOP  = '1;

    logic [RW-1:0] run_len;
    logic          wrong;

    // A compared bit that disagrees with the pattern.
    assign wrong = armed & (dout ^ exp_bit);

    // Error count, consecutive-error run and sticky failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_cnt <= '0;
            run_len <= '0;
            fail    <= 1'b0;
        end else if (wrong) begin
            if (err_cnt != CNT_TOP) err_cnt <= err_cnt + 1'b1;
            if (run_len != RUN_TOP) run_len <= run_len + 1'b1;
            if (run_len == RUN_LAST) fail   <= 1'b1;
        end else begin
            run_len <= '0;
        end
    end

endmodule

// File: rtl/cfg_monitor.sv
// Module cfg_monitor
// Watches for loss of configuration. A low done level sets a sticky
// loss flag. A canary passes straight through, and any difference between
// it and its returning copy sets a sticky degradation flag. Clear wins.
module cfg_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic done_in,
    input  logic canary_in,
    input  logic canary_back,
    output logic canary_out,
    output logic cfg_lost,
    output logic cfg_degraded
);
    // Feed-through path for the canary.
    assign canary_out = canary_in;

    // Sticky configuration flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cfg_lost     <= 1'b0;
            cfg_degraded <= 1'b0;
        end else begin
            cfg_lost     <= cfg_lost | ~done_in;
            cfg_degraded <= cfg_degraded | (canary_back ^ canary_in);
        end
    end

endmodule

// File: rtl/upset_harness.sv
// Module upset_harness
// Top of the upset test vehicle. One pattern source feeds LANES lanes.
// The lower half are plain and the upper half triplicated. Each lane has
// its own monitor, and one block watches the configuration signals.
// Assumes LANES is even and DEPTH >= 2.
module upset_harness #(
    parameter int LANES    = 8,
    parameter int DEPTH    = 500,
    parameter int FAIL_RUN = 16,
    parameter int CNT_W    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [1:0]             pat_sel,
    input  logic                   done_in,
    input  logic                   canary_in,
    input  logic                   canary_back,
    output logic                   canary_out,
    output logic [LANES-1:0]       chain_out,
    output logic [LANES*CNT_W-1:0] err_cnt,
    output logic [LANES-1:0]       fail_flags,
    output logic                   cfg_lost,
    output logic                   cfg_degraded
);
    localparam int PLAIN_LANES = LANES / 2;

    logic src_bit;
    logic exp_bit;
    logic armed;

    pattern_gen #(.DEPTH(DEPTH)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .pat_sel (pat_sel),
        .src_bit (src_bit),
        .exp_bit (exp_bit),
        .armed   (armed)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        shift_chain #(
            .DEPTH  (DEPTH),
            .TRIPLE (i >= PLAIN_LANES)
        ) u_chain (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (src_bit),
            .dout  (chain_out[i])
        );

        chain_monitor #(
            .CNT_W    (CNT_W),
            .FAIL_RUN (FAIL_RUN)
        ) u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .armed   (armed),
            .dout    (chain_out[i]),
            .exp_bit (exp_bit),
            .err_cnt (err_cnt[i*CNT_W +: CNT_W]),
            .fail    (fail_flags[i])
        );
    end

    cfg_monitor u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .done_in      (done_in),
        .canary_in    (canary_in),
        .canary_back  (canary_back),
        .canary_out   (canary_out),
        .cfg_lost     (cfg_lost),
        .cfg_degraded (cfg_degraded)
    );

endmodule

// File: rtl/harness_sva.sv
// Module harness_sva
// Property checks on the harness ports, attached to upset_harness by bind.
module harness_sva #(
    parameter int LANES = 8,
    parameter int CNT_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clr,
    input logic                   done_in,
    input logic                   canary_in,
    input logic                   canary_back,
    input logic [LANES*CNT_W-1:0] err_cnt,
    input logic [LANES-1:0]       fail_flags,
    input logic                   cfg_lost,
    input logic                   cfg_degraded
);
    a_r8_lost_on_done_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_in && !clr) |=> cfg_lost);

    a_r8_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lost && !clr) |=> cfg_lost);

    a_r9_degraded_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        ((canary_back != canary_in) && !clr) |=> cfg_degraded);

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_cnt == '0 && fail_flags == '0 && !cfg_lost && !cfg_degraded));

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        a_r5_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (err_cnt[i*CNT_W +: CNT_W] >= $past(err_cnt[i*CNT_W +: CNT_W])));

        a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (fail_flags[i] && !clr) |=> fail_flags[i]);

        a_r6_fail_has_errors: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fail_flags[i]) |-> (err_cnt[i*CNT_W +: CNT_W] != '0));
    end

endmodule

bind upset_harness harness_sva #(.LANES(LANES), .CNT_W(CNT_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .done_in      (done_in),
    .canary_in    (canary_in),
    .canary_back  (canary_back),
    .err_cnt      (err_cnt),
    .fail_flags   (fail_flags),
    .cfg_lost     (cfg_lost),
    .cfg_degraded (cfg_degraded)
);

// File: tb/sim_upset_harness.sv
`timescale 1ns/1ps
// Bench for upset_harness: a pattern table walked by one loop, then
// directed tests of injected upsets, runs, saturation, clear and config flags.
module sim_upset_harness;
    localparam int LANES    = 8;
    localparam int DEPTH    = 32;
    localparam int FAIL_RUN = 16;
    localparam int CNT_W    = 6;
    localparam int CNT_MAX  = (1 << CNT_W) - 1;

    logic                   clk = 1'b0;
    logic                   rst_n, clr, done_in, canary_in, canary_back;
    logic [1:0]             pat_sel;
    logic                   canary_out, cfg_lost, cfg_degraded;
    logic [LANES-1:0]       chain_out, fail_flags;
    logic [LANES*CNT_W-1:0] err_cnt;

    int n_chk  = 0;
    int n_fail = 0;

    upset_harness #(.LANES(LANES), .DEPTH(DEPTH), .FAIL_RUN(FAIL_RUN), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pat_sel(pat_sel), .done_in(done_in),
        .canary_in(canary_in), .canary_back(canary_back), .canary_out(canary_out),
        .chain_out(chain_out), .err_cnt(err_cnt), .fail_flags(fail_flags),
        .cfg_lost(cfg_lost), .cfg_degraded(cfg_degraded)
    );

    always #2 clk = ~clk;

    // Pattern table: [4:3] pat_sel, [2] checkerboard, [1] expected level, [0] spare.
    localparam logic [4:0] PAT_TAB [7] = '{
        5'b00_0_0_0, 5'b01_0_1_0, 5'b10_1_0_0, 5'b01_0_1_0,
        5'b11_0_0_0, 5'b10_1_0_0, 5'b00_0_0_0
    };

    function automatic int cnt_of(int idx);
        return int'(err_cnt[idx*CNT_W +: CNT_W]);
    endfunction

    function automatic logic [DEPTH-1:0] run_mask(int hi, int len);
        logic [DEPTH-1:0] m = '0;
        for (int b = hi - len + 1; b <= hi; b++) m[b] = 1'b1;
        return m;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
    endtask

    // Watch one lane for a window after an injection: first clock seen high and count of highs.
    task automatic watch(int lane, output int first_at, output int ones);
        first_at = -1;
        ones = 0;
        for (int c = 1; c <= DEPTH + 4; c++) begin
            @(negedge clk);
            if (chain_out[lane]) begin
                ones++;
                if (first_at < 0) first_at = c;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int first_at, ones;
        logic [LANES-1:0] b0, b1;
        rst_n = 1'b0; clr = 1'b0; pat_sel = 2'b00; done_in = 1'b1;
        canary_in = 1'b0; canary_back = 1'b0;
        tick(3);
        // R11: reset state
        check("R11 chain_out", int'(chain_out), 0);
        check("R11 err_cnt", int'(err_cnt != '0), 0);
        check("R11 flags", int'({fail_flags, cfg_lost, cfg_degraded}), 0);
        rst_n = 1'b1;
        tick(DEPTH + 4);

        // R2 / R7: pattern table walk; warm-up after each change must add no errors
        for (int e = 0; e < 7; e++) begin
            pat_sel = PAT_TAB[e][4:3];
            tick(DEPTH + 4);
            if (PAT_TAB[e][2]) begin
                b0 = chain_out;
                tick(1);
                b1 = chain_out;
                check("R2 checkerboard inverts", int'(b0 ^ b1), (1 << LANES) - 1);
                check("R2 checkerboard lanes agree", int'(b0 == '0 || b0 == '1), 1);
            end else begin
                check("R2 constant level", int'(chain_out), PAT_TAB[e][1] ? (1 << LANES) - 1 : 0);
            end
            check("R7 no errors after change", int'(err_cnt != '0), 0);
            check("R7 no failure after change", int'(fail_flags), 0);
        end

        // R3: single copy upsets in triplicated lanes (pattern is zeros)
        @(negedge clk); #1;
        force u0.g_lane[4].u_chain.stg_a = run_mask(10, 1);
        #1; release u0.g_lane[4].u_chain.stg_a;
        watch(4, first_at, ones);
        check("R3 mid stage masked", ones, 0);
        check("R3 mid stage count", cnt_of(4), 0);
        @(negedge clk); #1;
        force u0.g_lane[5].u_chain.stg_a = '1;
        #1; release u0.g_lane[5].u_chain.stg_a;
        watch(5, first_at, ones);
        check("R3 whole copy masked", ones + cnt_of(5), 0);
        @(negedge clk); #1;
        force u0.g_lane[6].u_chain.stg_a = run_mask(DEPTH - 1, 1);
        #1; release u0.g_lane[6].u_chain.stg_a;
        watch(6, first_at, ones);
        check("R3 last stage masked", ones + cnt_of(6), 0);

        // R4: single upset at stage 10 of plain lane 0
        @(negedge clk); #1;
        force u0.g_lane[0].u_chain.stg_a = run_mask(10, 1);
        #1; release u0.g_lane[0].u_chain.stg_a;
        watch(0, first_at, ones);
        check("R4 arrival clock", first_at, DEPTH - 1 - 10);
        check("R4 seen once", ones, 1);
        check("R4 count one", cnt_of(0), 1);

        // R1: lane 3 is plain, lane 7 is triplicated
        @(negedge clk); #1;
        force u0.g_lane[3].u_chain.stg_a = run_mask(4, 1);
        force u0.g_lane[7].u_chain.stg_a = run_mask(4, 1);
        #1;
        release u0.g_lane[3].u_chain.stg_a;
        release u0.g_lane[7].u_chain.stg_a;
        tick(DEPTH + 4);
        check("R1 lane 3 plain", cnt_of(3), 1);
        check("R1 lane 7 triplicated", cnt_of(7), 0);
        pulse_clr();

        // R6: runs of FAIL_RUN-1, FAIL_RUN, and two runs split by a good bit
        @(negedge clk); #1;
        force u0.g_lane[1].u_chain.stg_a = run_mask(DEPTH - 1, FAIL_RUN - 1);
        force u0.g_lane[2].u_chain.stg_a = run_mask(DEPTH - 1, FAIL_RUN);
        force u0.g_lane[3].u_chain.stg_a = run_mask(DEPTH - 1, 10) | run_mask(DEPTH - 12, 10);
        #1;
        release u0.g_lane[1].u_chain.stg_a;
        release u0.g_lane[2].u_chain.stg_a;
        release u0.g_lane[3].u_chain.stg_a;
        tick(DEPTH + 4);
        check("R6 short run count", cnt_of(1), FAIL_RUN - 1);
        check("R6 full run count", cnt_of(2), FAIL_RUN);
        check("R6 split run count", cnt_of(3), 20);
        check("R6 only full run fails", int'(fail_flags), 4);
        pulse_clr();

        // R5 / R10: persistent error on lane 0, clear during it, then saturation
        @(negedge clk); #1;
        force u0.g_lane[0].u_chain.stg_a = '1;
        tick(10);
        check("R5 one per wrong bit", cnt_of(0), 10);
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        check("R10 clear wins count", cnt_of(0), 0);
        check("R10 clear wins fail", int'(fail_flags[0]), 0);
        tick(5);
        check("R10 counting resumes", cnt_of(0), 5);
        tick(100);
        check("R5 saturates", cnt_of(0), CNT_MAX);
        check("R6 persistent fails", int'(fail_flags[0]), 1);
        release u0.g_lane[0].u_chain.stg_a;
        tick(DEPTH + 4);
        check("R5 stays saturated", cnt_of(0), CNT_MAX);
        pulse_clr();

        // R8: configuration-done low
        check("R8 idle", int'(cfg_lost), 0);
        done_in = 1'b0;
        tick(1);
        done_in = 1'b1;
        check("R8 set next clock", int'(cfg_lost), 1);
        tick(3);
        check("R8 sticky", int'(cfg_lost), 1);
        // R10: done low in the same cycle as clear
        done_in = 1'b0; clr = 1'b1;
        tick(1);
        clr = 1'b0;
        check("R10 clear beats done", int'(cfg_lost), 0);
        tick(1);
        done_in = 1'b1;
        check("R8 set after clear", int'(cfg_lost), 1);
        pulse_clr();

        // R9: canary feed-through and mismatch
        canary_in = 1'b1; canary_back = 1'b1;
        #1;
        check("R9 feed-through", int'(canary_out), 1);
        tick(2);
        check("R9 match no flag", int'(cfg_degraded), 0);
        canary_back = 1'b0;
        tick(1);
        canary_back = 1'b1;
        check("R9 mismatch flag", int'(cfg_degraded), 1);
        tick(2);
        check("R9 sticky", int'(cfg_degraded), 1);
        pulse_clr();
        check("R10 clears degraded", int'(cfg_degraded), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule